// File: doc/BRIEF.md
# Software Interrupt Level Gate

This block keeps the software interrupt request word and the current processor interrupt level for one hardware thread. It turns the pair into one pending line per request bit for the interrupt controller next to it. Software changes the request word in three ways. A plain load replaces the word. An OR-write sets only the bits that are 1 in the data. An AND-NOT-write clears only those bits. The clear and set forms let a handler change single bits without a read-modify-write race.

A strobe from the system-tick comparator sets the top request bit. The level register has its own load port. Both registers can always be read back.

Gating uses two rules. The lowest bit (tick match) and the highest bit (system-tick match) are allowed through only while the level is below a fixed threshold of 14. Each middle bit is allowed through only while its own index is strictly above the level. The pending lines are a combinational function of the two registers, so they follow any register change in the same cycle that the register takes its new value.

Top module: `softint_level_gate`

## Requirements
- R1: After reset the request word, the level and every pending line are all zero.
- R2: When no update input is active, the request word keeps its value. A plain load (`sw_load`) replaces the word with `sw_data`.
- R3: An OR-write (`sw_or`) sets every request bit that is 1 in `sw_data` and leaves the other bits unchanged.
- R4: An AND-NOT-write (`sw_andn`) clears every request bit that is 1 in `sw_data` and leaves the other bits unchanged.
- R5: When several software update inputs are active in one cycle, they apply in a fixed order: the load first, then the OR-write, then the AND-NOT-write, all with the same data.
- R6: `stick_hit` sets request bit 16. It takes effect after any AND-NOT-write in the same cycle, so bit 16 ends up 1 even if the clear data has bit 16 set.
- R7: `lvl_load` loads the 4-bit level from `lvl_data`. Otherwise the level holds its value.
- R8: Pending bits 0 and 16 equal their request bits while the level is 13 or less, and are 0 while the level is 14 or 15.
- R9: For each index i from 1 to 15, pending bit i is 1 exactly when request bit i is 1 and i is greater than the level.
- R10: The pending lines, `sw_rd` and `lvl_rd` show the effect of an update right after the clock edge that takes it, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_load | input | 1 | Replace the request word with `sw_data` |
| sw_or | input | 1 | OR `sw_data` into the request word |
| sw_andn | input | 1 | Clear the request bits that are 1 in `sw_data` |
| sw_data | input | 17 | Data for the request word updates |
| lvl_load | input | 1 | Load the level register |
| lvl_data | input | 4 | New level value |
| stick_hit | input | 1 | System-tick match strobe; sets bit 16 |
| sw_rd | output | 17 | Current request word |
| lvl_rd | output | 4 | Current level |
| pend | output | 17 | Pending line for each request bit |

## Verification
The hardest case to reach is a system-tick strobe that arrives in the same cycle as a clear aimed at bit 16, possibly with a load and an OR-write active too. Random stimulus seldom lines these up. Directed steps therefore drive every combination of the three software update inputs with and without the strobe. The level is also swept from 0 to 15 while a word with all bits set is held, so the threshold edges at 13/14 and at index equal to level are both covered. Seeded random traffic then mixes updates, and a bench function computes the pending lines in its own way to check against.

// File: rtl/softint_gate_pkg.sv
package softint_gate_pkg;

  // Software update requests for one cycle
  typedef struct packed {
    logic load;
    logic orw;
    logic andn;
  } sw_ops_t;

  localparam int DEF_SW_W   = 17;
  localparam int DEF_LVL_W  = 4;
  localparam int DEF_THRESH = 14;

endpackage

// File: rtl/softint_word_reg.sv
module softint_word_reg
  import softint_gate_pkg::*;
#(
  parameter int SW_W = DEF_SW_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  sw_ops_t         ops,
  input  logic [SW_W-1:0] data,
  input  logic            hit,
  output logic [SW_W-1:0] word_q
);

  localparam int HIT_BIT = SW_W - 1;

  // Fixed order: load, OR, AND-NOT, then the timer hit last so it is never lost
  function automatic logic [SW_W-1:0] merge_next(
    input logic [SW_W-1:0] cur,
    input sw_ops_t         op,
    input logic [SW_W-1:0] d,
    input logic            h
  );
    logic [SW_W-1:0] v;
    v = cur;
    if (op.load) v = d;
    if (op.orw)  v = v | d;
    if (op.andn) v = v & ~d;
    if (h)       v[HIT_BIT] = 1'b1;
    return v;
  endfunction

  logic [SW_W-1:0] word_d;
  logic            any_upd;

  assign any_upd = ops.load | ops.orw | ops.andn | hit;

  always_comb begin
    word_d = merge_next(word_q, ops, data, hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_upd |=> $stable(word_q));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ops.load && !ops.orw && !ops.andn && !hit) |=> (word_q == $past(data)));

  assert_or_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ops.orw && !ops.andn) |=> ((word_q & $past(data)) == $past(data)));

  assert_andn_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ops.andn && !hit) |=> ((word_q & $past(data)) == '0));

  assert_hit_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> word_q[HIT_BIT]);

endmodule

// File: rtl/softint_level_reg.sv
module softint_level_reg
  import softint_gate_pkg::*;
#(
  parameter int LVL_W = DEF_LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LVL_W-1:0] wd,
  output logic [LVL_W-1:0] lvl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lvl_q <= '0;
    else if (we) lvl_q <= wd;
  end

  assert_lvl_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (lvl_q == $past(wd)));

  assert_lvl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(lvl_q));

endmodule

// File: rtl/softint_pend_mask.sv
module softint_pend_mask
  import softint_gate_pkg::*;
#(
  parameter int SW_W   = DEF_SW_W,
  parameter int LVL_W  = DEF_LVL_W,
  parameter int THRESH = DEF_THRESH
) (
  input  logic [SW_W-1:0]  word,
  input  logic [LVL_W-1:0] lvl,
  output logic [SW_W-1:0]  pend
);

  localparam int TOP = SW_W - 1;

  // Tick bits: a fixed ceiling on the level
  function automatic logic fixed_open(input logic [LVL_W-1:0] l);
    return 32'(l) < THRESH;
  endfunction

  // Middle bits: the index must be strictly above the level
  function automatic logic index_open(input int idx, input logic [LVL_W-1:0] l);
    return 32'(l) < idx;
  endfunction

  for (genvar b = 0; b < SW_W; b++) begin : g_bit
    if (b == 0 || b == TOP) begin : g_fixed
      assign pend[b] = word[b] & fixed_open(lvl);
    end else begin : g_index
      assign pend[b] = word[b] & index_open(b, lvl);
    end
  end

endmodule

// File: rtl/softint_level_gate.sv
module softint_level_gate
  import softint_gate_pkg::*;
#(
  parameter int SW_W   = DEF_SW_W,
  parameter int LVL_W  = DEF_LVL_W,
  parameter int THRESH = DEF_THRESH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_load,
  input  logic             sw_or,
  input  logic             sw_andn,
  input  logic [SW_W-1:0]  sw_data,
  input  logic             lvl_load,
  input  logic [LVL_W-1:0] lvl_data,
  input  logic             stick_hit,
  output logic [SW_W-1:0]  sw_rd,
  output logic [LVL_W-1:0] lvl_rd,
  output logic [SW_W-1:0]  pend
);

  localparam int TOP = SW_W - 1;

  sw_ops_t         ops;
  logic [SW_W-1:0] word_q;
  logic [LVL_W-1:0] lvl_q;

  assign ops = '{load: sw_load, orw: sw_or, andn: sw_andn};

  softint_word_reg #(.SW_W(SW_W)) u_word (
    .clk(clk), .rst_n(rst_n), .ops(ops), .data(sw_data),
    .hit(stick_hit), .word_q(word_q)
  );

  softint_level_reg #(.LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .we(lvl_load), .wd(lvl_data), .lvl_q(lvl_q)
  );

  softint_pend_mask #(.SW_W(SW_W), .LVL_W(LVL_W), .THRESH(THRESH)) u_mask (
    .word(word_q), .lvl(lvl_q), .pend(pend)
  );

  assign sw_rd  = word_q;
  assign lvl_rd = lvl_q;

  assert_fixed_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lvl_q) >= THRESH) |-> (!pend[0] && !pend[TOP]));

  assert_fixed_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lvl_q) < THRESH) |-> (pend[0] == word_q[0] && pend[TOP] == word_q[TOP]));

  assert_index_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != '0 && 32'(lvl_q) < TOP) |-> !pend[lvl_q]);

  assert_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~word_q) == '0);

endmodule

// File: tb/softint_level_gate_tb.sv
module softint_level_gate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SW_W  = 17;
  localparam int LVL_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_load = 0, sw_or = 0, sw_andn = 0, lvl_load = 0, stick_hit = 0;
  logic [SW_W-1:0]  sw_data = '0;
  logic [LVL_W-1:0] lvl_data = '0;
  logic [SW_W-1:0]  sw_rd, pend;
  logic [LVL_W-1:0] lvl_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [SW_W-1:0]  m_word = '0;
  logic [LVL_W-1:0] m_lvl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softint_level_gate dut_i (
    .clk(clk), .rst_n(rst_n), .sw_load(sw_load), .sw_or(sw_or),
    .sw_andn(sw_andn), .sw_data(sw_data), .lvl_load(lvl_load),
    .lvl_data(lvl_data), .stick_hit(stick_hit), .sw_rd(sw_rd),
    .lvl_rd(lvl_rd), .pend(pend)
  );

  // Expected pending lines, computed bit by bit from the rules
  function automatic logic [SW_W-1:0] want_pend(input logic [SW_W-1:0] w,
                                                 input logic [LVL_W-1:0] l);
    logic [SW_W-1:0] r;
    int lv;
    lv = int'(l);
    r = '0;
    for (int i = 0; i < SW_W; i++) begin
      if (i == 0 || i == 16) r[i] = w[i] && (lv <= 13);
      else                   r[i] = w[i] && (i > lv);
    end
    return r;
  endfunction

  function automatic logic [SW_W-1:0] want_word(input logic [SW_W-1:0] w,
      input bit ld, input bit o, input bit a, input bit h, input logic [SW_W-1:0] d);
    logic [SW_W-1:0] r;
    r = ld ? d : w;
    r = o ? (r | d) : r;
    r = a ? (r & ~d) : r;
    if (h) r = r | (17'h1 << 16);
    return r;
  endfunction

  task automatic check_all(input string tag);
    logic [SW_W-1:0] ep;
    ep = want_pend(m_word, m_lvl);
    checks++;
    if (sw_rd !== m_word) begin
      errors++;
      $display("FAIL %s word: actual %h expected %h", tag, sw_rd, m_word);
    end
    checks++;
    if (lvl_rd !== m_lvl) begin
      errors++;
      $display("FAIL %s level: actual %0d expected %0d", tag, lvl_rd, m_lvl);
    end
    checks++;
    if (pend !== ep) begin
      errors++;
      $display("FAIL %s pend: actual %h expected %h (lvl %0d)", tag, pend, ep, m_lvl);
    end
  endtask

  // One clock of stimulus, model update, then check after the edge
  task automatic step(input bit ld, input bit o, input bit a, input logic [SW_W-1:0] d,
                      input bit lw, input logic [LVL_W-1:0] ldat, input bit h,
                      input string tag);
    @(negedge clk);
    sw_load = ld; sw_or = o; sw_andn = a; sw_data = d;
    lvl_load = lw; lvl_data = ldat; stick_hit = h;
    @(posedge clk);
    m_word = want_word(m_word, ld, o, a, h, d);
    if (lw) m_lvl = ldat;
    #1;
    check_all(tag);
    @(negedge clk);
    sw_load = 0; sw_or = 0; sw_andn = 0; lvl_load = 0; stick_hit = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state holds when idle; R2 hold
    step(0, 0, 0, 17'h1ffff, 0, 4'd0, 0, "R2 idle with data");
    step(1, 0, 0, 17'h0a5a5, 0, 4'd0, 0, "R2 load");
    step(0, 0, 0, 17'h1ffff, 0, 4'd0, 0, "R2 hold");
    step(0, 1, 0, 17'h10003, 0, 4'd0, 0, "R3 or");
    step(0, 0, 1, 17'h00021, 0, 4'd0, 0, "R4 andn");
    step(0, 1, 0, 17'h00000, 0, 4'd5, 0, "R4 R3 zero data");

    // R5 ordering with all combinations
    for (int c = 1; c < 8; c++) begin
      step(1, 0, 0, 17'h0f0f0, 0, 4'd0, 0, "R5 preset");
      step(c[0], c[1], c[2], 17'h13c3c, 0, 4'd0, 0, "R5 combo");
    end

    // R6: hit alone, and hit with clear of bit 16 in every combination
    step(1, 0, 0, 17'h00000, 0, 4'd0, 0, "R6 preset");
    step(0, 0, 0, 17'h00000, 0, 4'd0, 1, "R6 hit alone");
    for (int c = 0; c < 8; c++) begin
      step(0, 0, 0, 17'h00000, 0, 4'd0, 1, "R6 arm");
      step(c[0], c[1], 1'b1, 17'h1ffff, 0, 4'd0, 1, "R6 clear plus hit");
    end
    step(0, 0, 1, 17'h10000, 0, 4'd0, 0, "R4 clear bit 16");

    // R7, R8, R9, R10: sweep level with every request bit set
    step(1, 0, 0, 17'h1ffff, 0, 4'd0, 0, "R10 all set");
    for (int l = 0; l < 16; l++) begin
      step(0, 0, 0, 17'h00000, 1, 4'(l), 0, "R7 R8 R9 level sweep");
    end
    for (int l = 15; l >= 0; l--) begin
      step(0, 0, 0, 17'h00000, 1, 4'(l), 0, "R8 R9 down sweep");
    end
    step(0, 0, 0, 17'h00000, 1, 4'd13, 0, "R8 level 13");
    step(1, 0, 0, 17'h10001, 0, 4'd0, 0, "R8 ticks at 13");
    step(0, 0, 0, 17'h00000, 1, 4'd14, 0, "R8 ticks at 14");
    step(0, 0, 1, 17'h00001, 1, 4'd3, 0, "R10 both regs same cycle");

    // Seeded random traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[2], r[3], 17'($urandom), r[4], 4'($urandom), r[5] & r[6],
           "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    finish_run();
  end

endmodule